// File: doc/BRIEF.md
# Snoop Response Collector

On a shared snooping bus with N caches, every transaction placed on the bus needs an answer from each of the other caches. A cache reports whether it holds a valid copy of the requested line, whether its copy is modified, and whether it is still working on the snoop. This block merges those per-cache indications into three combined lines. It decides when the snoop phase is over. It then tells the requesting cache which state to use when it fills a read miss.

A transaction begins when the start strobe is seen while the block is idle. At that edge the block latches the requester's index and the completion mode. In bounded mode, the phase lasts a fixed number of cycles, set by a parameter. In tracking mode, the phase ends as soon as the combined pending line reads zero. At the end of the phase the block emits a single-cycle done pulse and captures the combined shared and dirty lines. It then presents a fill-state code that stays in place until the next phase ends.

Top module: `snoop_collect`

## Requirements
- R1: `line_shared` is the OR of `cache_shared[i]` over every cache i other than the requester, where bit i belongs to cache i and the requester is the `req_id` latched at the most recently accepted start.
- R2: `line_dirty` is the OR of `cache_dirty[i]` over every cache other than the latched requester.
- R3: `line_pending` is the OR of `cache_pending[i]` over every cache other than the latched requester. The requester's own pending bit has no effect.
- R4: When `mode_wired` is 0 at the accepting edge, `snoop_done` rises exactly WAIT clock edges after that edge (default 4), whatever `cache_pending` does.
- R5: When `mode_wired` is 1 at the accepting edge, `snoop_done` rises at the first edge that follows a cycle, counted from the accepting edge onward, in which `line_pending` is 0.
- R6: `snoop_done` is high for exactly one cycle. `snap_shared` and `snap_dirty` take the values `line_shared` and `line_dirty` had in the cycle just before the pulse, and hold them until the next pulse.
- R7: `fill_state` encodes the fill decision from the captured lines: 2'b00 means Exclusive (neither line set), 2'b01 means Shared with data from memory (shared set, dirty clear), and 2'b11 means Shared with data supplied by the owning cache (dirty set, whatever shared is).
- R8: A `txn_start` that arrives while a phase is in progress is ignored: the end time, the requester and the mode all stay unchanged. A start during the cycle in which `snoop_done` is high is accepted.
- R9: After reset, `snoop_done` is 0, `fill_state` is 2'b00, both snapshot outputs are 0, and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txn_start | input | 1 | Strobe that starts a snoop phase |
| mode_wired | input | 1 | Completion mode: 0 = bounded, 1 = tracking |
| req_id | input | $clog2(N) | Index of the requesting cache |
| cache_shared | input | N | Per-cache valid-copy indication |
| cache_dirty | input | N | Per-cache modified-copy indication |
| cache_pending | input | N | Per-cache snoop-still-running indication |
| line_shared | output | 1 | Combined shared line |
| line_dirty | output | 1 | Combined dirty line |
| line_pending | output | 1 | Combined pending line |
| snoop_done | output | 1 | One-cycle end-of-phase pulse |
| snap_shared | output | 1 | Shared line captured at the end of the phase |
| snap_dirty | output | 1 | Dirty line captured at the end of the phase |
| fill_state | output | 2 | Fill decision code, as listed in R7 |

## Verification
The bench drives the inverse of the intended shared and dirty values until the final cycle of each phase. A collector that samples one cycle early or late would therefore report the opposite fill state. The requester's own shared bit is set while every other cache is clear, and its own pending bit is held stuck at 1 in tracking mode. A design that failed to mask the requester would report Shared, or would never finish the phase. A second start is injected partway through a phase with a different requester and mode; if it were accepted, the pulse would move or the masking would change. Phases are also run back to back with no gap, and a phase is run whose pending line is already clear in its first cycle. These two cases catch off-by-one errors in acceptance and release.

// File: rtl/snoop_pkg.sv
package snoop_pkg;

  typedef enum logic [1:0] {
    FILL_EXCL       = 2'b00,
    FILL_SHARED_MEM = 2'b01,
    FILL_SHARED_OWN = 2'b11
  } fill_e;

  // Fill decision from the captured lines: a modified copy elsewhere wins.
  function automatic fill_e pick_fill(input logic shared_seen, input logic dirty_seen);
    if (dirty_seen)       return FILL_SHARED_OWN;
    else if (shared_seen) return FILL_SHARED_MEM;
    else                  return FILL_EXCL;
  endfunction

endpackage

// File: rtl/snoop_or_lines.sv
module snoop_or_lines #(
  parameter int N   = 4,
  parameter int IDW = 2
) (
  input  logic [IDW-1:0] self_id,
  input  logic [N-1:0]   vec_shared,
  input  logic [N-1:0]   vec_dirty,
  input  logic [N-1:0]   vec_pending,
  output logic           or_shared,
  output logic           or_dirty,
  output logic           or_pending
);
  logic [N-1:0] others;

  for (genvar g = 0; g < N; g++) begin : g_mask
    assign others[g] = (self_id != IDW'(g));
  end

  assign or_shared  = |(vec_shared  & others);
  assign or_dirty   = |(vec_dirty   & others);
  assign or_pending = |(vec_pending & others);
endmodule

// File: rtl/snoop_phase_ctrl.sv
module snoop_phase_ctrl #(
  parameter int WAIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic txn_start,
  input  logic mode_wired,
  input  logic pending_line,
  output logic accept,
  output logic busy,
  output logic capture,
  output logic mode_q
);
  localparam int CNT_W = (WAIT < 2) ? 1 : $clog2(WAIT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WAIT - 1);

  logic [CNT_W-1:0] cnt;
  logic             bound_hit;

  assign accept    = txn_start && !busy;
  assign bound_hit = (cnt == LAST);
  assign capture   = busy && (mode_q ? !pending_line : bound_hit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt    <= '0;
      mode_q <= 1'b0;
    end else if (accept) begin
      busy   <= 1'b1;
      cnt    <= '0;
      mode_q <= mode_wired;
    end else if (capture) begin
      busy   <= 1'b0;
    end else if (busy && !bound_hit) begin
      cnt    <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/snoop_result_reg.sv
module snoop_result_reg
  import snoop_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       capture,
  input  logic       shared_line,
  input  logic       dirty_line,
  output logic       done,
  output logic       snap_shared,
  output logic       snap_dirty,
  output logic [1:0] fill_code
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done        <= 1'b0;
      snap_shared <= 1'b0;
      snap_dirty  <= 1'b0;
      fill_code   <= FILL_EXCL;
    end else begin
      done <= capture;
      if (capture) begin
        snap_shared <= shared_line;
        snap_dirty  <= dirty_line;
        fill_code   <= pick_fill(shared_line, dirty_line);
      end
    end
  end
endmodule

// File: rtl/snoop_collect.sv
module snoop_collect #(
  parameter int N    = 4,
  parameter int WAIT = 4,
  localparam int IDW = (N < 2) ? 1 : $clog2(N)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           txn_start,
  input  logic           mode_wired,
  input  logic [IDW-1:0] req_id,
  input  logic [N-1:0]   cache_shared,
  input  logic [N-1:0]   cache_dirty,
  input  logic [N-1:0]   cache_pending,
  output logic           line_shared,
  output logic           line_dirty,
  output logic           line_pending,
  output logic           snoop_done,
  output logic           snap_shared,
  output logic           snap_dirty,
  output logic [1:0]     fill_state
);
  logic           accept;
  logic           busy;
  logic           capture;
  logic           mode_q;
  logic [IDW-1:0] req_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      req_q <= '0;
    else if (accept) req_q <= req_id;
  end

  snoop_or_lines #(.N(N), .IDW(IDW)) u_lines (
    .self_id    (req_q),
    .vec_shared (cache_shared),
    .vec_dirty  (cache_dirty),
    .vec_pending(cache_pending),
    .or_shared  (line_shared),
    .or_dirty   (line_dirty),
    .or_pending (line_pending)
  );

  snoop_phase_ctrl #(.WAIT(WAIT)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .txn_start   (txn_start),
    .mode_wired  (mode_wired),
    .pending_line(line_pending),
    .accept      (accept),
    .busy        (busy),
    .capture     (capture),
    .mode_q      (mode_q)
  );

  snoop_result_reg u_res (
    .clk        (clk),
    .rst_n      (rst_n),
    .capture    (capture),
    .shared_line(line_shared),
    .dirty_line (line_dirty),
    .done       (snoop_done),
    .snap_shared(snap_shared),
    .snap_dirty (snap_dirty),
    .fill_code  (fill_state)
  );
endmodule

// File: rtl/snoop_collect_chk.sv
module snoop_collect_chk #(
  parameter int N    = 4,
  parameter int WAIT = 4,
  parameter int IDW  = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           txn_start,
  input logic           accept,
  input logic           busy,
  input logic           mode_q,
  input logic [IDW-1:0] req_q,
  input logic           line_shared,
  input logic           line_pending,
  input logic           snoop_done,
  input logic           snap_shared,
  input logic           snap_dirty,
  input logic [1:0]     fill_state
);
  localparam int CW = $clog2(WAIT + 2);
  localparam logic [CW-1:0] CMAX = CW'(WAIT + 1);

  logic [CW-1:0] since_acc;

  always_ff @(posedge clk) begin
    if (!rst_n)                since_acc <= '0;
    else if (accept)           since_acc <= '0;
    else if (since_acc != CMAX) since_acc <= since_acc + 1'b1;
  end

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_done |=> !snoop_done);

  a_r4_fixed_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_done && !mode_q) |-> (since_acc == CW'(WAIT)));

  a_r5_release_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_done && mode_q) |-> ($past(line_pending) == 1'b0));

  a_r5_hold_while_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mode_q && line_pending) |=> !snoop_done);

  a_r6_snap_capture: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_done |-> (snap_shared == $past(line_shared)));

  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (!snap_shared && !snap_dirty) |-> (fill_state == 2'b00));

  a_r7_owner_supplies: assert property (@(posedge clk) disable iff (!rst_n)
    snap_dirty |-> (fill_state == 2'b11));

  a_r8_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && txn_start) |=> ($stable(req_q) && $stable(mode_q)));
endmodule

bind snoop_collect snoop_collect_chk #(.N(N), .WAIT(WAIT), .IDW(IDW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .txn_start   (txn_start),
  .accept      (accept),
  .busy        (busy),
  .mode_q      (mode_q),
  .req_q       (req_q),
  .line_shared (line_shared),
  .line_pending(line_pending),
  .snoop_done  (snoop_done),
  .snap_shared (snap_shared),
  .snap_dirty  (snap_dirty),
  .fill_state  (fill_state)
);

// File: tb/snoop_collect_test.sv
module snoop_collect_test;
  localparam int N = 4;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         txn_start = 1'b0;
  logic         mode_wired = 1'b0;
  logic [1:0]   req_id = '0;
  logic [N-1:0] cache_shared = '0;
  logic [N-1:0] cache_dirty = '0;
  logic [N-1:0] cache_pending = '0;
  logic         line_shared, line_dirty, line_pending;
  logic         snoop_done, snap_shared, snap_dirty;
  logic [1:0]   fill_state;

  always #2 clk = ~clk;

  snoop_collect #(.N(N), .WAIT(W)) uut (
    .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .mode_wired(mode_wired),
    .req_id(req_id), .cache_shared(cache_shared), .cache_dirty(cache_dirty),
    .cache_pending(cache_pending), .line_shared(line_shared), .line_dirty(line_dirty),
    .line_pending(line_pending), .snoop_done(snoop_done), .snap_shared(snap_shared),
    .snap_dirty(snap_dirty), .fill_state(fill_state)
  );

  typedef struct {
    int   at_cyc;
    logic sh;
    logic dt;
  } exp_t;

  exp_t expq[$];
  int   checks = 0;
  int   errors = 0;
  int   cyc = 0;
  bit   finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int fill_of(input logic sh, input logic dt);
    if (dt) return 3;
    return sh ? 1 : 0;
  endfunction

  // Monitor: compare each pulse against the scoreboard.
  always @(negedge clk) begin
    if (rst_n && snoop_done) begin
      if (expq.size() == 0) begin
        check(1'b0, "R8 unexpected snoop_done", 1, 0);
      end else begin
        exp_t e;
        e = expq.pop_front();
        check(cyc == e.at_cyc, "R4/R5 done timing", cyc, e.at_cyc);
        check(snap_shared == e.sh, "R6 snap_shared", snap_shared, e.sh);
        check(snap_dirty == e.dt, "R6 snap_dirty", snap_dirty, e.dt);
        check(fill_state == 2'(fill_of(e.sh, e.dt)), "R7 fill_state",
              fill_state, fill_of(e.sh, e.dt));
      end
    end
  end

  // Driver: called at a negedge; returns at the negedge of the done cycle.
  task automatic do_txn(input logic wired, input int req, input logic [N-1:0] sh,
                        input logic [N-1:0] dt, input int drops[N], input int ign_at);
    int   len;
    int   last;
    logic [N-1:0] others;
    exp_t e;
    others = ~(N'(1) << req);
    last = 0;
    for (int i = 0; i < N; i++)
      if (i != req && drops[i] > last) last = drops[i];
    len = wired ? last + 1 : W;
    e.at_cyc = cyc + 1 + len;
    e.sh = |(sh & others);
    e.dt = |(dt & others);
    expq.push_back(e);
    txn_start     = 1'b1;
    mode_wired    = wired;
    req_id        = 2'(req);
    cache_shared  = ~sh;
    cache_dirty   = ~dt;
    cache_pending = '1;
    for (int j = 0; j < len; j++) begin
      @(negedge clk);
      txn_start = (j == ign_at);
      if (j == ign_at) begin
        req_id     = 2'((req + 1) % N);
        mode_wired = ~wired;
      end
      for (int i = 0; i < N; i++)
        cache_pending[i] = wired ? ((i == req) || (j < drops[i])) : 1'b1;
      cache_shared = (j == len - 1) ? sh : ~sh;
      cache_dirty  = (j == len - 1) ? dt : ~dt;
      if (j == len - 1) begin
        #1;
        check(line_shared == e.sh, "R1 line_shared", line_shared, e.sh);
        check(line_dirty == e.dt, "R2 line_dirty", line_dirty, e.dt);
        check(line_pending == !wired, "R3 line_pending", line_pending, !wired);
      end
    end
    @(negedge clk);
    txn_start = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    int z[N];
    int d[N];
    z = '{0, 0, 0, 0};
    repeat (3) @(negedge clk);
    check(snoop_done == 1'b0, "R9 reset done", snoop_done, 0);
    check(fill_state == 2'b00, "R9 reset fill", fill_state, 0);
    check(snap_shared == 1'b0, "R9 reset snap_shared", snap_shared, 0);
    check(snap_dirty == 1'b0, "R9 reset snap_dirty", snap_dirty, 0);
    rst_n = 1'b1;
    idle(2);
    // R4 fixed bound, shared copy elsewhere -> Shared from memory
    do_txn(1'b0, 0, 4'b0010, 4'b0000, z, -1);
    idle(2);
    // R1 requester's own copy excluded -> Exclusive
    do_txn(1'b0, 1, 4'b0010, 4'b0000, z, -1);
    idle(1);
    // R7 dirty elsewhere -> owner supplies
    do_txn(1'b0, 2, 4'b0000, 4'b1000, z, -1);
    // R8 back-to-back start in the done cycle
    do_txn(1'b0, 3, 4'b0101, 4'b0100, z, -1);
    idle(2);
    // R5 tracking mode, pending drops at varying times, R3 requester stuck pending
    d = '{9, 3, 1, 2};
    do_txn(1'b1, 0, 4'b0100, 4'b0000, d, -1);
    idle(1);
    // R5 pending already clear in first cycle
    do_txn(1'b1, 2, 4'b0000, 4'b0000, z, -1);
    idle(1);
    // R8 second start mid-phase ignored (fixed mode)
    do_txn(1'b0, 1, 4'b0011, 4'b0000, z, 1);
    idle(W + 3);
    // R8 second start mid-phase ignored (tracking mode)
    d = '{4, 0, 5, 0};
    do_txn(1'b1, 3, 4'b1000, 4'b0010, d, 2);
    idle(W + 3);
    check(expq.size() == 0, "R6 all pulses seen", expq.size(), 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule